// File: doc/BRIEF.md
# NAND Flash Logical Unit Model

This block is a synthesizable behavioural model of a single logical unit that sits behind a NAND flash target controller. It contains a small page array, a page register as wide as one page, and an 8-bit status byte. The controller hands it a complete row address and an operation code in one cycle. The unit then reads a page into the page register, programs the page register into the array, erases a whole block, or fills the page register with a device description.

Ready/busy is reported only through status bit 6. A busy period has two parts. First comes a byte-per-cycle transfer phase, so the array maps onto an inferred single-port-write RAM. Then a drain phase removes a pseudo-random step of 1 to 4 units per cycle from a work counter. Busy time therefore varies between operations but always stays within a bound. The page register is reached through a byte port with an auto-incrementing column pointer.

Top module: `nand_lun`

## Requirements
- R1: After a synchronous reset the status byte reads 0x40, `byte_rdata` is 0x00, every page-register byte is 0x00 and the column pointer is 0.
- R2: A request accepted while status bit 6 is 1 (`req_valid` high; `req_op` 0 = page read, 1 = page program, 2 = block erase, 3 = parameter load) makes status bit 6 read 0 in the very next cycle.
- R3: The number of cycles that status bit 6 stays 0 lies between X+1+ceil(W/4) and X+1+W. Here W is `WORK_UNITS` and X is the page size in bytes, or the block size in bytes for an erase.
- R4: A page read copies the addressed array page into the page register. A page program copies the page register into the addressed array page.
- R5: A block erase sets every byte of all pages in block `req_row / PAGES_PER_BLOCK` to 0xFF and leaves the other blocks unchanged.
- R6: A parameter load fills the page register as follows: byte 0 is the page size, byte 1 is pages per block, byte 2 is the block count, and all other bytes are 0x00. The array is not changed.
- R7: A request made while status bit 6 is 0 is ignored: no operation starts and no array data changes. It sets status bit 1, which stays set until reset.
- R8: A program or erase accepted while `wp` is high runs its busy period but leaves the array unchanged, and sets status bit 0 when it completes. Status bit 0 is cleared when the next request is accepted.
- R9: `col_load` sets the column pointer to `col_in`. `byte_wr` writes `byte_wdata` at the pointer. `byte_rd` returns the byte at the pointer on `byte_rdata` in the next cycle. Both `byte_wr` and `byte_rd` advance the pointer, which wraps from the last column to 0. `col_load` takes priority over the other two in the same cycle.
- R10: While status bit 6 is 0, `col_load`, `byte_wr` and `byte_rd` have no effect on the page register, the pointer or `byte_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe from the target controller |
| req_op | input | 2 | Operation code: 0 read, 1 program, 2 erase, 3 parameter load |
| req_row | input | ROW_W (4) | Full row address, block in the upper bits |
| wp | input | 1 | Write protect, sampled when a request is accepted |
| col_load | input | 1 | Load the column pointer |
| col_in | input | COL_W (3) | Column value to load |
| byte_wr | input | 1 | Write one page-register byte |
| byte_wdata | input | 8 | Byte to write |
| byte_rd | input | 1 | Read one page-register byte |
| byte_rdata | output | 8 | Registered read byte |
| status | output | 8 | Bit 6 ready, bit 1 busy-request error, bit 0 protect failure |

## Verification
Four kinds of sequence drive the array path. Programs with distinct ramp patterns on different rows show whether row and column addressing are correct. Erases of a block next to a programmed page show whether the erase stays inside its block. Protected program and erase show that a blocked write still runs its busy period. Parameter loads show that the page register is filled from the description and not from the array. The busy length is measured on every operation against a window rather than an exact count, because the step sequence is pseudo-random. Busy-time requests and byte accesses are injected mid-operation, and their absence of effect is then confirmed by reading the page back and reading the same row again.

// File: rtl/nand_lun_pkg.sv
package nand_lun_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_PARAM = 2'd3
  } lun_op_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_XFER  = 2'd1,
    S_DRAIN = 2'd2
  } lun_state_e;

  localparam int SR_READY    = 6;
  localparam int SR_REQERR   = 1;
  localparam int SR_PROTFAIL = 0;
endpackage

// File: rtl/nand_lun_step_gen.sv
module nand_lun_step_gen #(
  parameter int          MAX_STEP = 4,
  parameter logic [7:0]  SEED     = 8'hB7,
  localparam int         STEP_W   = $clog2(MAX_STEP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [STEP_W-1:0] step
);
  logic [7:0] lfsr;
  logic       fb;

  assign fb = lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr <= SEED;
      step <= STEP_W'(1);
    end else begin
      lfsr <= {lfsr[6:0], fb};
      step <= STEP_W'((int'(lfsr) % MAX_STEP) + 1);
    end
  end
endmodule

// File: rtl/nand_lun_array.sv
module nand_lun_array #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [2**ADDR_W];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nand_lun_page_reg.sv
module nand_lun_page_reg #(
  parameter int PAGE_BYTES = 8,
  localparam int COL_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             col_load,
  input  logic [COL_W-1:0] col_in,
  input  logic             host_wr,
  input  logic [7:0]       host_wdata,
  input  logic             host_rd,
  output logic [7:0]       host_rdata,
  input  logic             int_we,
  input  logic [COL_W-1:0] int_addr,
  input  logic [7:0]       int_wdata,
  input  logic [COL_W-1:0] int_raddr,
  output logic [7:0]       int_rdata
);
  logic [7:0]       pg [PAGE_BYTES];
  logic [COL_W-1:0] ptr;

  assign int_rdata = pg[int_raddr];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr        <= '0;
      host_rdata <= 8'h00;
      for (int i = 0; i < PAGE_BYTES; i++) pg[i] <= 8'h00;
    end else if (busy) begin
      if (int_we) pg[int_addr] <= int_wdata;
    end else if (col_load) begin
      ptr <= col_in;
    end else if (host_wr) begin
      pg[ptr] <= host_wdata;
      ptr     <= ptr + 1'b1;
    end else if (host_rd) begin
      host_rdata <= pg[ptr];
      ptr        <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/nand_lun_ctrl.sv
module nand_lun_ctrl
  import nand_lun_pkg::*;
#(
  parameter int PAGE_BYTES      = 8,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int NUM_BLOCKS      = 4,
  parameter int WORK_UNITS      = 12,
  parameter int MAX_STEP        = 4,
  localparam int COL_W  = $clog2(PAGE_BYTES),
  localparam int PG_W   = $clog2(PAGES_PER_BLOCK),
  localparam int ROW_W  = $clog2(PAGES_PER_BLOCK * NUM_BLOCKS),
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int STEP_W = $clog2(MAX_STEP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              wp,
  input  logic [STEP_W-1:0] step,
  output logic [7:0]        status,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [7:0]        arr_wdata,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [7:0]        arr_rdata,
  output logic              pg_we,
  output logic [COL_W-1:0]  pg_addr,
  output logic [7:0]        pg_wdata,
  output logic [COL_W-1:0]  pg_raddr,
  input  logic [7:0]        pg_rdata
);
  localparam int BLK_W  = PG_W + COL_W;
  localparam int IDX_W  = BLK_W + 1;
  localparam int WORK_W = $clog2(WORK_UNITS + 1);
  localparam int BLK_BYTES = PAGES_PER_BLOCK * PAGE_BYTES;

  lun_state_e       state;
  lun_op_e          op_q;
  logic [ROW_W-1:0] row_q;
  logic             blocked_q;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_m1;
  logic [IDX_W-1:0] xfer_last;
  logic [WORK_W-1:0] work;
  logic             ready_q, err_q, pfail_q;
  logic [COL_W-1:0] col;

  function automatic logic [7:0] param_byte(input logic [COL_W-1:0] c);
    case (int'(c))
      0:       return 8'(PAGE_BYTES);
      1:       return 8'(PAGES_PER_BLOCK);
      2:       return 8'(NUM_BLOCKS);
      default: return 8'h00;
    endcase
  endfunction

  assign col       = idx[COL_W-1:0];
  assign idx_m1    = idx - IDX_W'(1);
  assign xfer_last = (op_q == OP_ERASE) ? IDX_W'(BLK_BYTES) : IDX_W'(PAGE_BYTES);
  assign busy      = (state != S_IDLE);
  assign status    = {1'b0, ready_q, 4'b0000, err_q, pfail_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_READ;
      row_q     <= '0;
      blocked_q <= 1'b0;
      idx       <= '0;
      work      <= '0;
      ready_q   <= 1'b1;
      err_q     <= 1'b0;
      pfail_q   <= 1'b0;
    end else begin
      if (req_valid && state != S_IDLE) err_q <= 1'b1;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q      <= lun_op_e'(req_op);
            row_q     <= req_row;
            blocked_q <= wp && (req_op == OP_PROG || req_op == OP_ERASE);
            idx       <= '0;
            work      <= WORK_W'(WORK_UNITS);
            ready_q   <= 1'b0;
            pfail_q   <= 1'b0;
            state     <= S_XFER;
          end
        end
        S_XFER: begin
          if (idx == xfer_last) state <= S_DRAIN;
          else                  idx   <= idx + IDX_W'(1);
        end
        S_DRAIN: begin
          if (int'(work) <= int'(step)) begin
            state   <= S_IDLE;
            ready_q <= 1'b1;
            pfail_q <= blocked_q;
          end else begin
            work <= work - WORK_W'(step);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = {row_q, col};
    arr_wdata = 8'hFF;
    arr_raddr = {row_q, col};
    pg_we     = 1'b0;
    pg_addr   = col;
    pg_wdata  = arr_rdata;
    pg_raddr  = col;
    if (state == S_XFER) begin
      case (op_q)
        OP_READ: begin
          if (idx != '0) begin
            pg_we    = 1'b1;
            pg_addr  = idx_m1[COL_W-1:0];
            pg_wdata = arr_rdata;
          end
        end
        OP_PARAM: begin
          if (idx < IDX_W'(PAGE_BYTES)) begin
            pg_we    = 1'b1;
            pg_wdata = param_byte(col);
          end
        end
        OP_PROG: begin
          if (idx < IDX_W'(PAGE_BYTES) && !blocked_q) begin
            arr_we    = 1'b1;
            arr_wdata = pg_rdata;
          end
        end
        OP_ERASE: begin
          if (idx < IDX_W'(BLK_BYTES) && !blocked_q) begin
            arr_we    = 1'b1;
            arr_waddr = {row_q[ROW_W-1:PG_W], idx[BLK_W-1:0]};
            arr_wdata = 8'hFF;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nand_lun.sv
module nand_lun #(
  parameter int         PAGE_BYTES      = 8,
  parameter int         PAGES_PER_BLOCK = 4,
  parameter int         NUM_BLOCKS      = 4,
  parameter int         WORK_UNITS      = 12,
  parameter int         MAX_STEP        = 4,
  parameter logic [7:0] LFSR_SEED       = 8'hB7,
  localparam int COL_W = $clog2(PAGE_BYTES),
  localparam int ROW_W = $clog2(PAGES_PER_BLOCK * NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [ROW_W-1:0] req_row,
  input  logic             wp,
  input  logic             col_load,
  input  logic [COL_W-1:0] col_in,
  input  logic             byte_wr,
  input  logic [7:0]       byte_wdata,
  input  logic             byte_rd,
  output logic [7:0]       byte_rdata,
  output logic [7:0]       status
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int STEP_W = $clog2(MAX_STEP + 1);

  logic [STEP_W-1:0] step;
  logic              busy;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr, arr_raddr;
  logic [7:0]        arr_wdata, arr_rdata;
  logic              pg_we;
  logic [COL_W-1:0]  pg_addr, pg_raddr;
  logic [7:0]        pg_wdata, pg_rdata;

  nand_lun_step_gen #(.MAX_STEP(MAX_STEP), .SEED(LFSR_SEED)) u_step (
    .clk(clk), .rst(rst), .step(step)
  );

  nand_lun_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .NUM_BLOCKS(NUM_BLOCKS), .WORK_UNITS(WORK_UNITS), .MAX_STEP(MAX_STEP)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_row(req_row), .wp(wp), .step(step), .status(status), .busy(busy),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .pg_we(pg_we), .pg_addr(pg_addr), .pg_wdata(pg_wdata),
    .pg_raddr(pg_raddr), .pg_rdata(pg_rdata)
  );

  nand_lun_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );

  nand_lun_page_reg #(.PAGE_BYTES(PAGE_BYTES)) u_page (
    .clk(clk), .rst(rst), .busy(busy), .col_load(col_load), .col_in(col_in),
    .host_wr(byte_wr), .host_wdata(byte_wdata), .host_rd(byte_rd),
    .host_rdata(byte_rdata), .int_we(pg_we), .int_addr(pg_addr),
    .int_wdata(pg_wdata), .int_raddr(pg_raddr), .int_rdata(pg_rdata)
  );
endmodule

// File: rtl/nand_lun_checker.sv
module nand_lun_checker #(
  parameter int PAGE_BYTES      = 8,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int WORK_UNITS      = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [7:0] status,
  input logic [7:0] byte_rdata
);
  localparam int MAX_BUSY = PAGES_PER_BLOCK * PAGE_BYTES + 1 + WORK_UNITS;

  logic [15:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || status[6]) busy_cnt <= '0;
    else                  busy_cnt <= busy_cnt + 16'd1;
  end

  a_r1_reset_status: assert property (@(posedge clk)
    rst |=> (status == 8'h40));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (status[6] && req_valid) |=> !status[6]);

  a_r3_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt <= 16'(MAX_BUSY)));

  a_r7_err_on_busy_req: assert property (@(posedge clk) disable iff (rst)
    (!status[6] && req_valid) |=> status[1]);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    status[1] |=> status[1]);

  a_r8_pfail_at_completion: assert property (@(posedge clk) disable iff (rst)
    $rose(status[0]) |-> $rose(status[6]));

  a_r8_pfail_clear_on_accept: assert property (@(posedge clk) disable iff (rst)
    (status[6] && req_valid) |=> !status[0]);

  a_r10_rdata_hold_busy: assert property (@(posedge clk) disable iff (rst)
    !status[6] |=> $stable(byte_rdata));
endmodule

bind nand_lun nand_lun_checker #(
  .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .WORK_UNITS(WORK_UNITS)
) u_nand_lun_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .status(status), .byte_rdata(byte_rdata)
);

// File: tb/test_nand_lun.sv
`timescale 1ns/1ps
module test_nand_lun;
  localparam int PB   = 8;
  localparam int PPB  = 4;
  localparam int NB   = 4;
  localparam int WORK = 12;
  localparam int NV   = 11;

  typedef struct packed {
    logic [1:0] op;
    logic [3:0] row;
    logic       wp;
    logic [7:0] pat;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd1, 4'd1,  1'b0, 8'h10},
    '{2'd1, 4'd5,  1'b0, 8'h30},
    '{2'd0, 4'd1,  1'b0, 8'h00},
    '{2'd2, 4'd2,  1'b0, 8'h00},
    '{2'd0, 4'd5,  1'b0, 8'h00},
    '{2'd0, 4'd1,  1'b0, 8'h00},
    '{2'd1, 4'd6,  1'b1, 8'h55},
    '{2'd2, 4'd4,  1'b1, 8'h00},
    '{2'd3, 4'd0,  1'b0, 8'h00},
    '{2'd1, 4'd14, 1'b0, 8'hE0},
    '{2'd0, 4'd5,  1'b0, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic [1:0] req_op;
  logic [3:0] req_row;
  logic       wp;
  logic       col_load;
  logic [2:0] col_in;
  logic       byte_wr;
  logic [7:0] byte_wdata;
  logic       byte_rd;
  logic [7:0] byte_rdata;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [7:0] mdl    [PB*PPB*NB];
  logic [7:0] exp_pg [PB];

  always #4 clk = ~clk;

  nand_lun i_nand_lun (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_row(req_row), .wp(wp), .col_load(col_load), .col_in(col_in),
    .byte_wr(byte_wr), .byte_wdata(byte_wdata), .byte_rd(byte_rd),
    .byte_rdata(byte_rdata), .status(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [3:0] row, input logic wpv);
    int xl, lo, hi, n;
    bit exp_pf;
    xl = (op == 2'd2) ? PB * PPB : PB;
    lo = xl + 1 + (WORK + 3) / 4;
    hi = xl + 1 + WORK;
    exp_pf = wpv && (op == 2'd1 || op == 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_row = row; wp = wpv;
    @(negedge clk);
    req_valid = 1'b0; wp = 1'b0;
    chk(status[6] == 1'b0, "R2 busy after accept", status[6], 0);
    chk(status[0] == 1'b0, "R8 protect flag cleared on accept", status[0], 0);
    n = 0;
    while (!status[6]) begin
      n++;
      @(negedge clk);
    end
    chk(n >= lo && n <= hi, "R3 busy length window", n, lo);
    chk(status[0] == exp_pf, "R8 protect flag at completion", status[0], exp_pf);
  endtask

  task automatic page_fill(input logic [7:0] pat);
    @(negedge clk);
    col_load = 1'b1; col_in = 3'd0;
    @(negedge clk);
    col_load = 1'b0;
    for (int i = 0; i < PB; i++) begin
      byte_wr = 1'b1; byte_wdata = pat + 8'(i);
      @(negedge clk);
    end
    byte_wr = 1'b0;
  endtask

  task automatic page_check(input string tag);
    @(negedge clk);
    col_load = 1'b1; col_in = 3'd0;
    @(negedge clk);
    col_load = 1'b0; byte_rd = 1'b1;
    for (int i = 0; i < PB; i++) begin
      @(negedge clk);
      chk(byte_rdata == exp_pg[i], tag, byte_rdata, exp_pg[i]);
    end
    byte_rd = 1'b0;
  endtask

  task automatic exp_from_row(input int row);
    for (int i = 0; i < PB; i++) exp_pg[i] = mdl[row * PB + i];
  endtask

  task automatic model_erase(input int row);
    int b;
    b = row / PPB;
    for (int i = 0; i < PB * PPB; i++) mdl[b * PB * PPB + i] = 8'hFF;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R3: actual busy without end expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t cur;
    string tag;
    logic [7:0] hold;
    rst = 1'b1; req_valid = 1'b0; req_op = 2'd0; req_row = 4'd0; wp = 1'b0;
    col_load = 1'b0; col_in = 3'd0; byte_wr = 1'b0; byte_wdata = 8'h00; byte_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(status == 8'h40, "R1 reset status", status, 8'h40);
    chk(byte_rdata == 8'h00, "R1 reset rdata", byte_rdata, 0);
    for (int i = 0; i < PB; i++) exp_pg[i] = 8'h00;
    page_check("R1 reset page register");

    // R5: erase every block to set a known array
    for (int b = 0; b < NB; b++) begin
      run_op(2'd2, 4'(b * PPB), 1'b0);
      model_erase(b * PPB);
    end

    // Table walk
    for (int v = 0; v < NV; v++) begin
      cur = VECS[v];
      if (cur.wp) tag = "R8 protected op";
      else if (cur.op == 2'd2) tag = "R5 erase";
      else if (cur.op == 2'd3) tag = "R6 parameter load";
      else tag = "R4 read/program";
      if (cur.op == 2'd1) page_fill(cur.pat);
      run_op(cur.op, cur.row, cur.wp);
      if (cur.op == 2'd1 && !cur.wp)
        for (int i = 0; i < PB; i++) mdl[int'(cur.row) * PB + i] = cur.pat + 8'(i);
      if (cur.op == 2'd2 && !cur.wp) model_erase(int'(cur.row));
      if (cur.op == 2'd0) begin
        exp_from_row(int'(cur.row));
        page_check(tag);
      end else if (cur.op == 2'd3) begin
        for (int i = 0; i < PB; i++) exp_pg[i] = 8'h00;
        exp_pg[0] = 8'(PB); exp_pg[1] = 8'(PPB); exp_pg[2] = 8'(NB);
        page_check(tag);
        run_op(2'd0, 4'd14, 1'b0);
        exp_from_row(14);
        page_check("R6 array unchanged");
      end else begin
        run_op(2'd0, cur.row, 1'b0);
        exp_from_row(int'(cur.row));
        page_check(tag);
      end
    end

    // R7 and R10: requests and byte accesses while busy
    chk(status[1] == 1'b0, "R7 no error before busy request", status[1], 0);
    hold = byte_rdata;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_row = 4'd5;
    @(negedge clk);
    req_op = 2'd2; req_row = 4'd4;
    col_load = 1'b1; col_in = 3'd3;
    @(negedge clk);
    req_valid = 1'b0; col_load = 1'b0;
    byte_wr = 1'b1; byte_wdata = 8'hAA;
    @(negedge clk);
    byte_wr = 1'b0; byte_rd = 1'b1;
    @(negedge clk);
    byte_rd = 1'b0;
    chk(byte_rdata == hold, "R10 rdata unchanged while busy", byte_rdata, hold);
    chk(status[1] == 1'b1, "R7 error set by busy request", status[1], 1);
    while (!status[6]) @(negedge clk);
    exp_from_row(5);
    page_check("R10 page register untouched while busy");
    run_op(2'd0, 4'd5, 1'b0);
    page_check("R7 ignored erase left row intact");
    chk(status[1] == 1'b1, "R7 error sticky", status[1], 1);

    // R9: wrap and load priority
    @(negedge clk);
    col_load = 1'b1; col_in = 3'd7;
    @(negedge clk);
    col_load = 1'b0; byte_wr = 1'b1; byte_wdata = 8'h11;
    @(negedge clk);
    byte_wdata = 8'h22;
    @(negedge clk);
    byte_wr = 1'b1; byte_wdata = 8'h99; col_load = 1'b1; col_in = 3'd7;
    @(negedge clk);
    byte_wr = 1'b0; col_load = 1'b0; byte_rd = 1'b1;
    @(negedge clk);
    chk(byte_rdata == 8'h11, "R9 last column and load priority", byte_rdata, 8'h11);
    @(negedge clk);
    byte_rd = 1'b0;
    chk(byte_rdata == 8'h22, "R9 pointer wraps to column 0", byte_rdata, 8'h22);

    // R1: reset clears error
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(status == 8'h40, "R1 reset clears status", status, 8'h40);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule